// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which of four operating modes the processor core is in: Active, Power Save, Idle or Halt. Software programs it through one byte-wide control/status register. A WAIT strobe from the core and a hardware wake-up event move it between modes. Two clock-health flags, one for the high-frequency clock and one for the low-frequency clock, can block a move.

The outputs drive the clock tree and the core:
- the reported mode;
- the enable for the high-frequency oscillator;
- the select that puts the core on the low-frequency clock;
- a stall line that holds the core in Idle and Halt.

Power Save can be entered in two ways. In the first, software requests it and the switch starts immediately, and the register reports the mode only once the switch is done. In the second, the request is armed, the register shows it at once, and entry waits for the next WAIT strobe.

After a wake-up from a mode where the high-frequency oscillator was off, the controller turns the oscillator on. It stays in a resume state, still reporting the mode it left, until the high-frequency clock is stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, register bits 5..0 read 0, `mode_o` is Active, `hf_osc_en` is 1, `lf_clk_sel` is 0 and `cpu_stall` is 0. The mode encoding is Active=0, Power Save=1, Idle=2, Halt=3.
- R2: The register layout is as follows. Bit 7 reads `lf_stable` and bit 6 reads `hf_stable`, and writes to these two bits are ignored. Bit 5 is the defer bit, bit 4 always reads 0, bit 3 is halt, bit 2 is idle, bit 1 is oscillator-off and bit 0 is power-save.
- R3: Writing bit 0 = 1 with bit 5 = 0 from Active starts an immediate switch. During the switch, `mode_o` stays Active, `lf_clk_sel` is 1 and bit 0 still reads 0. On the first clock with `lf_stable` = 1, the mode becomes Power Save and bit 0 reads 1.
- R4: Writing bit 0 = 1 with bit 5 = 1 makes bit 0 read 1 on the next cycle. The mode stays Active until a WAIT strobe, which then enters Power Save.
- R5: From Active, a WAIT strobe moves the mode only when bit 5 is 1. Entry into Idle or Power Save from Active also needs `lf_stable` = 1. Entry into Halt needs no clock flag.
- R6: On a WAIT strobe the halt bit wins over the idle bit, and the idle bit wins over the power-save bit. If the idle request is blocked by `lf_stable` = 0, nothing is entered.
- R7: From Power Save, a WAIT strobe enters Halt or Idle without needing bit 5 or `lf_stable`.
- R8: A wake-up event clears bits 3..0. If `hf_stable` is 1, or the mode was already Active, the mode becomes Active on the next cycle.
- R9: A wake-up event with `hf_stable` = 0 from a non-Active mode enters a resume state. In this state `mode_o` holds the mode being left, `hf_osc_en` = 1 and `lf_clk_sel` = 1. The mode becomes Active on the first clock with `hf_stable` = 1.
- R10: `hf_osc_en` is 1 in Active, during an immediate switch and while resuming. It is 0 in Halt. In Power Save and Idle it is the inverse of bit 1.
- R11: `cpu_stall` is 1 exactly in Idle and Halt, and drops on the cycle after a wake-up event.
- R12: A WAIT strobe has no effect in Active with no request armed. It also has no effect in any cycle that carries a register write.
- R13: Writing bit 0 = 0 during an immediate switch or in Power Save leaves for Active. If `hf_stable` is 0, the controller enters the resume state instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| wait_strobe | input | 1 | One-cycle WAIT instruction pulse |
| wake_evt | input | 1 | Hardware wake-up event |
| hf_stable | input | 1 | High-frequency clock stable |
| lf_stable | input | 1 | Low-frequency clock stable |
| mode_o | output | 2 | Current mode |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| lf_clk_sel | output | 1 | 1 = core runs on low-frequency clock |
| cpu_stall | output | 1 | Core held stalled |

## Verification
The bench aims at these corner cases:
- **Reporting the power-save bit.** It reads 0 throughout an immediate switch held back by a low `lf_stable`, but 1 right after a deferred request. A design that mixed the two would report Power Save before the clock moved, or hide an armed request.
- **Halt versus Idle, and clock gating.** It sets halt and idle together, and it tries Idle with the low clock unstable. A wrong priority would stall into Idle while the oscillator ran; a missing gate would enter Idle on a dead clock.
- **Wake-up from Halt with `hf_stable` low.** A design without the resume state would report Active with the core still on the slow clock.
- **Same-cycle write and WAIT, and mixed traffic.** A WAIT in the same cycle as a write must be dropped. A long mixed-traffic run checks every output against a reference model every cycle.

// File: rtl/pmc_pkg.sv
// Shared types and register bit positions for the low-power mode controller.
package pmc_pkg;

    localparam int REG_W  = 8;
    localparam int B_LFS  = 7;
    localparam int B_HFS  = 6;
    localparam int B_WBPS = 5;
    localparam int B_RSV  = 4;
    localparam int B_HALT = 3;
    localparam int B_IDLE = 2;
    localparam int B_DHF  = 1;
    localparam int B_PSM  = 0;

    typedef enum logic [1:0] {
        MODE_ACT   = 2'd0,
        MODE_PSAVE = 2'd1,
        MODE_IDLE  = 2'd2,
        MODE_HALT  = 2'd3
    } pm_mode_e;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLOWING,
        ST_PSAVE,
        ST_IDLE,
        ST_HALT,
        ST_RESUME
    } pm_state_e;

    typedef struct packed {
        logic wbps;
        logic halt;
        logic idle;
        logic dhf;
        logic psm;
    } pm_ctl_t;

    // Mode reported for a given FSM state (resume state handled by caller).
    function automatic pm_mode_e mode_of(input pm_state_e s);
        case (s)
            ST_PSAVE: return MODE_PSAVE;
            ST_IDLE:  return MODE_IDLE;
            ST_HALT:  return MODE_HALT;
            default:  return MODE_ACT;
        endcase
    endfunction

endpackage

// File: rtl/pmc_ctl_reg.sv
// Writable control bits of the mode register.
// Assumes: wake-up outranks a write; a write outranks the switch-done set.
module pmc_ctl_reg
    import pmc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         wake_evt,
    input  logic         psm_done,
    output pm_ctl_t      ctl
);

    // Update control bits from reset, wake-up, CPU write or switch completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wake_evt) begin
            ctl.psm  <= 1'b0;
            ctl.dhf  <= 1'b0;
            ctl.idle <= 1'b0;
            ctl.halt <= 1'b0;
        end else if (wr_en) begin
            ctl.wbps <= wdata[B_WBPS];
            ctl.halt <= wdata[B_HALT];
            ctl.idle <= wdata[B_IDLE];
            ctl.dhf  <= wdata[B_DHF];
            ctl.psm  <= wdata[B_PSM] & (wdata[B_WBPS] | ctl.psm | psm_done);
        end else if (psm_done) begin
            ctl.psm  <= 1'b1;
        end
    end

endmodule

// File: rtl/pmc_mode_fsm.sv
// Mode sequencer: immediate/deferred entry, clock-flag gating, wake-up resume.
// Assumes: wait_strobe is a single-cycle pulse; a WAIT in a write cycle is dropped.
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pm_ctl_t      ctl,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         wait_strobe,
    input  logic         wake_evt,
    input  logic         hf_stable,
    input  logic         lf_stable,
    output pm_state_e    state,
    output pm_mode_e     wake_from,
    output logic         psm_done
);

    pm_state_e state_nxt;
    pm_state_e exit_st;
    logic      wr_clr;
    logic      wr_now;
    logic      wait_ok;

    assign wr_clr  = wr_en & ~wdata[B_PSM];
    assign wr_now  = wr_en & wdata[B_PSM] & ~wdata[B_WBPS];
    assign wait_ok = wait_strobe & ~wr_en;
    assign exit_st = hf_stable ? ST_RUN : ST_RESUME;

    // Next-state selection; wake-up outranks every other cause.
    always_comb begin
        state_nxt = state;
        psm_done  = 1'b0;
        if (wake_evt) begin
            if (state != ST_RUN) state_nxt = exit_st;
        end else begin
            case (state)
                ST_RUN: begin
                    if (wr_now) begin
                        state_nxt = ST_SLOWING;
                    end else if (wait_ok && ctl.wbps) begin
                        if (ctl.halt)                  state_nxt = ST_HALT;
                        else if (ctl.idle) begin
                            if (lf_stable)             state_nxt = ST_IDLE;
                        end else if (ctl.psm && lf_stable) state_nxt = ST_PSAVE;
                    end
                end
                ST_SLOWING: begin
                    if (wr_clr) begin
                        state_nxt = exit_st;
                    end else if (lf_stable) begin
                        state_nxt = ST_PSAVE;
                        psm_done  = 1'b1;
                    end
                end
                ST_PSAVE: begin
                    if (wr_clr)                  state_nxt = exit_st;
                    else if (wait_ok && ctl.halt) state_nxt = ST_HALT;
                    else if (wait_ok && ctl.idle) state_nxt = ST_IDLE;
                end
                ST_RESUME: begin
                    if (hf_stable) state_nxt = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // Remember the mode being left when the resume state is entered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_from <= MODE_ACT;
        else if (state_nxt == ST_RESUME && state != ST_RESUME)
            wake_from <= mode_of(state);
    end

endmodule

// File: rtl/pmc_out_dec.sv
// Output decode from FSM state: mode code, oscillator enable, clock select, stall.
// Assumes: purely combinational, no added latency.
module pmc_out_dec
    import pmc_pkg::*;
(
    input  pm_state_e  state,
    input  pm_mode_e   wake_from,
    input  logic       dhf,
    output logic [1:0] mode_o,
    output logic       hf_osc_en,
    output logic       lf_clk_sel,
    output logic       cpu_stall
);

    // Per-state output values.
    always_comb begin
        mode_o     = mode_of(state);
        hf_osc_en  = 1'b1;
        lf_clk_sel = 1'b1;
        cpu_stall  = 1'b0;
        case (state)
            ST_RUN:    lf_clk_sel = 1'b0;
            ST_PSAVE:  hf_osc_en  = ~dhf;
            ST_IDLE: begin
                hf_osc_en = ~dhf;
                cpu_stall = 1'b1;
            end
            ST_HALT: begin
                hf_osc_en = 1'b0;
                cpu_stall = 1'b1;
            end
            ST_RESUME: mode_o = wake_from;
            default: ;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Low-power mode controller top: control register, mode FSM and output decode.
// Assumes: clock-flag inputs are already synchronous to clk.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr_en,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         wait_strobe,
    input  logic         wake_evt,
    input  logic         hf_stable,
    input  logic         lf_stable,
    output logic [1:0]   mode_o,
    output logic         hf_osc_en,
    output logic         lf_clk_sel,
    output logic         cpu_stall
);

    pm_ctl_t   ctl;
    pm_state_e state;
    pm_mode_e  wake_from;
    logic      psm_done;

    pmc_ctl_reg #(.W(W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .wake_evt (wake_evt),
        .psm_done (psm_done),
        .ctl      (ctl)
    );

    pmc_mode_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl         (ctl),
        .wr_en       (reg_wr_en),
        .wdata       (reg_wdata),
        .wait_strobe (wait_strobe),
        .wake_evt    (wake_evt),
        .hf_stable   (hf_stable),
        .lf_stable   (lf_stable),
        .state       (state),
        .wake_from   (wake_from),
        .psm_done    (psm_done)
    );

    pmc_out_dec u_dec (
        .state      (state),
        .wake_from  (wake_from),
        .dhf        (ctl.dhf),
        .mode_o     (mode_o),
        .hf_osc_en  (hf_osc_en),
        .lf_clk_sel (lf_clk_sel),
        .cpu_stall  (cpu_stall)
    );

    // Read view: live clock flags on top, control bits below, reserved bit zero.
    always_comb begin
        reg_rdata         = '0;
        reg_rdata[B_LFS]  = lf_stable;
        reg_rdata[B_HFS]  = hf_stable;
        reg_rdata[B_WBPS] = ctl.wbps;
        reg_rdata[B_HALT] = ctl.halt;
        reg_rdata[B_IDLE] = ctl.idle;
        reg_rdata[B_DHF]  = ctl.dhf;
        reg_rdata[B_PSM]  = ctl.psm;
    end

endmodule

// File: rtl/pmc_checker.sv
// Property checker for pwr_mode_ctrl, attached by bind.
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_evt,
    input logic       hf_stable,
    input logic       lf_stable,
    input logic [7:0] reg_rdata,
    input logic [1:0] mode_o,
    input logic       hf_osc_en,
    input logic       cpu_stall
);

    // Wake-up clears the four mode-request bits.
    assert_wake_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (reg_rdata[3:0] == 4'h0));

    // Arrival in Active only with a stable fast clock.
    assert_active_needs_hf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd0 && $past(mode_o) != 2'd0) |-> $past(hf_stable));

    // Active to Power Save or Idle only with a stable slow clock.
    assert_lowclk_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'd0 && (mode_o == 2'd1 || mode_o == 2'd2)) |-> $past(lf_stable));

    // Halt keeps the fast oscillator off.
    assert_halt_osc_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && cpu_stall) |-> !hf_osc_en);

    // Stall drops once wake-up has been seen.
    assert_stall_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !cpu_stall);

    // Stall only in Idle or Halt.
    assert_stall_modes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> mode_o[1]);

endmodule

bind pwr_mode_ctrl pmc_checker i_pmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_evt  (wake_evt),
    .hf_stable (hf_stable),
    .lf_stable (lf_stable),
    .reg_rdata (reg_rdata),
    .mode_o    (mode_o),
    .hf_osc_en (hf_osc_en),
    .cpu_stall (cpu_stall)
);

// File: tb/test_pwr_mode_ctrl.sv
// Bench: behavioural reference model compared with every output on every clock.
module test_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       wait_s = 1'b0;
    logic       wake = 1'b0;
    logic       hf = 1'b1;
    logic       lf = 1'b1;
    logic [7:0] rdata;
    logic [1:0] mode;
    logic       hf_en, sel, stall;

    int nvec = 0;
    int nfail = 0;

    // model state
    int m_mode = 0, m_wkfrom = 0;
    bit m_sw = 0, m_wk = 0;
    bit m_wb = 0, m_h = 0, m_i = 0, m_d = 0, m_p = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (wr_en),
        .reg_wdata   (wdata),
        .reg_rdata   (rdata),
        .wait_strobe (wait_s),
        .wake_evt    (wake),
        .hf_stable   (hf),
        .lf_stable   (lf),
        .mode_o      (mode),
        .hf_osc_en   (hf_en),
        .lf_clk_sel  (sel),
        .cpu_stall   (stall)
    );

    task automatic m_exit(input int from);
        m_sw = 0;
        m_mode = 0;
        if (hf) m_wk = 0;
        else begin
            if (!m_wk) m_wkfrom = from;
            m_wk = 1;
        end
    endtask

    // Advance the model by one clock using the inputs currently applied.
    task automatic m_step();
        bit ap, done;
        int from;
        ap   = (m_mode == 0) && !m_sw && !m_wk;
        from = m_wk ? m_wkfrom : m_mode;
        if (!rst_n) begin
            m_mode = 0; m_wkfrom = 0; m_sw = 0; m_wk = 0;
            m_wb = 0; m_h = 0; m_i = 0; m_d = 0; m_p = 0;
        end else if (wake) begin
            m_p = 0; m_d = 0; m_i = 0; m_h = 0;
            if (!ap) m_exit(from);
        end else begin
            done = m_sw && lf && !(wr_en && !wdata[0]);
            if (wr_en) begin
                m_p  = wdata[0] & (wdata[5] | m_p | done);
                m_wb = wdata[5]; m_h = wdata[3]; m_i = wdata[2]; m_d = wdata[1];
            end else if (done) m_p = 1;
            if (m_wk) begin
                if (hf) m_wk = 0;
            end else if (wr_en && !wdata[0] && (m_sw || m_mode == 1)) begin
                m_exit(from);
            end else if (done) begin
                m_sw = 0; m_mode = 1;
            end else if (wr_en) begin
                if (ap && wdata[0] && !wdata[5]) m_sw = 1;
            end else if (wait_s) begin
                if (ap && m_wb) begin
                    if (m_h) m_mode = 3;
                    else if (m_i) begin if (lf) m_mode = 2; end
                    else if (m_p && lf) m_mode = 1;
                end else if (m_mode == 1) begin
                    if (m_h) m_mode = 3;
                    else if (m_i) m_mode = 2;
                end
            end
        end
    endtask

    task automatic compare(input string req);
        logic [1:0] e_mode;
        logic       e_hf, e_sel, e_stall;
        logic [7:0] e_rd;
        e_mode  = 2'(m_wk ? m_wkfrom : m_mode);
        e_hf    = (m_wk || m_sw || m_mode == 0) ? 1'b1 : (m_mode == 3 ? 1'b0 : !m_d);
        e_sel   = m_wk || m_sw || (m_mode != 0);
        e_stall = !m_wk && (m_mode >= 2);
        e_rd    = {lf, hf, m_wb, 1'b0, m_h, m_i, m_d, m_p};
        nvec++;
        if ({mode, hf_en, sel, stall, rdata} !== {e_mode, e_hf, e_sel, e_stall, e_rd}) begin
            nfail++;
            $display("FAIL %s: got mode=%0d hf_en=%b sel=%b stall=%b rd=%h, expected mode=%0d hf_en=%b sel=%b stall=%b rd=%h",
                     req, mode, hf_en, sel, stall, rdata, e_mode, e_hf, e_sel, e_stall, e_rd);
        end
    endtask

    // One clock: model step, edge, then compare 1 ns after the edge.
    task automatic tick(input string req);
        m_step();
        @(posedge clk);
        #1;
        compare(req);
    endtask

    task automatic wr(input logic [7:0] d, input string req);
        wr_en = 1'b1; wdata = d;
        tick(req);
        wr_en = 1'b0;
    endtask

    task automatic do_wait(input string req);
        wait_s = 1'b1;
        tick(req);
        wait_s = 1'b0;
    endtask

    task automatic do_wake(input string req);
        wake = 1'b1;
        tick(req);
        wake = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        nfail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        @(posedge clk); #1;
        tick("R1 reset");
        tick("R1 reset");
        rst_n = 1'b1;
        tick("R1 idle after reset");

        // R2: status bits follow inputs, writes to them ignored
        lf = 1'b0;
        wr(8'hC0, "R2 status write ignored");
        tick("R2 status readback");
        lf = 1'b1;
        tick("R2 status readback");

        // R12: WAIT with nothing armed; WAIT in write cycle dropped
        do_wait("R12 wait no request");
        wait_s = 1'b1;
        wr(8'h24, "R12 wait with write dropped");
        wait_s = 1'b0;
        tick("R12 still active");
        do_wait("R5 idle entry");
        tick("R11 stall in idle");
        do_wake("R8 wake from idle");

        // R5: no defer bit, then low clock unstable
        wr(8'h04, "R5 idle armed no defer");
        do_wait("R5 wait ignored without defer");
        lf = 1'b0;
        wr(8'h24, "R5 idle armed");
        do_wait("R5 idle blocked by lf");
        lf = 1'b1;
        tick("R5 idle blocked by lf");

        // R6/R9: halt priority, wake with fast clock down
        wr(8'h2D, "R6 all armed");
        do_wait("R6 halt wins");
        tick("R10 halt osc off");
        hf = 1'b0;
        do_wake("R9 resume from halt");
        tick("R9 resume hold");
        tick("R9 resume hold");
        hf = 1'b1;
        tick("R9 resume done");
        tick("R9 active");

        // R3: immediate switch held by low clock
        lf = 1'b0;
        wr(8'h01, "R3 switch start");
        tick("R3 switch pending");
        tick("R3 switch pending");
        lf = 1'b1;
        tick("R3 switch done");
        wr(8'h03, "R10 osc off in power save");
        wr(8'h07, "R7 idle armed in power save");
        do_wait("R7 idle from power save");
        tick("R10 idle osc follows bit");
        do_wake("R8 wake from idle");

        // R4: deferred request
        wr(8'h21, "R4 deferred arm");
        tick("R4 still active");
        tick("R4 still active");
        do_wait("R4 enter on wait");
        tick("R10 power save osc on");
        wr(8'h20, "R13 clear in power save");
        tick("R13 active");

        // R13: abort an immediate switch; R9 wake from power save with hf low
        lf = 1'b0;
        wr(8'h01, "R13 switch start");
        wr(8'h00, "R13 switch abort");
        lf = 1'b1;
        wr(8'h01, "R3 switch start");
        tick("R3 in power save");
        hf = 1'b0;
        do_wake("R9 resume from power save");
        tick("R9 resume hold");
        hf = 1'b1;
        tick("R9 resume done");
        do_wake("R8 wake in active");

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            wr_en  = ($urandom_range(0, 7) == 0);
            wdata  = 8'($urandom);
            wait_s = ($urandom_range(0, 5) == 0);
            wake   = ($urandom_range(0, 20) == 0);
            hf     = ($urandom_range(0, 5) != 0);
            lf     = ($urandom_range(0, 5) != 0);
            tick("R12 mixed traffic");
        end
        wr_en = 1'b0; wait_s = 1'b0; wake = 1'b0; hf = 1'b1; lf = 1'b1;
        tick("R8 mixed tail");
        finish_run();
    end

endmodule